// File: doc/BRIEF.md
# Region Freeze Bridge Controller

This block sits between software and a reconfigurable logic region. It lets software hold the region isolated while the region is being replaced, and release it afterwards. Software works through four 32-bit word registers on a simple register bus. Reads are registered, so read data appears on the cycle after the read strobe. One register gives the handshake status, one takes requests, one logs refused requests, and one holds a fixed identification word.

A freeze request raises the isolation output at once. The block then waits for the region to report that it has gone quiet, and reports the frozen state. An unfreeze request drops the isolation output, and the unfrozen state is reported one cycle later. While the region is frozen, software may hold the region in reset through the request register. A request that does not fit the present state is refused and leaves a sticky flag. Software clears the flags by writing 1.

Top module: `rgn_iso_ctrl`

## Requirements
- R1: After reset the block is unfrozen. The status word (byte offset 0) reads 2 (bit 0 is freeze-done, bit 1 is unfreeze-done). `freeze_out` and `region_rst` are low, and the control word (offset 4) and the refusal log (offset 8) both read 0.
- R2: Offset 12 reads the constant 0xAD000003. Writes to offsets 0 and 12 change nothing that can be read back.
- R3: A control write with bit 0 set and bit 2 clear, made while unfreeze-done is set, raises `freeze_out` on the next cycle and clears status to 0. Status becomes 1 on the cycle after `quiesce_in` is sampled high, and not before.
- R4: A control write with bit 2 set and bit 0 clear, made while freeze-done is set, lowers `freeze_out` on the next cycle. Status then reads 0 for exactly one cycle and reads 2 after that.
- R5: `region_rst` is high exactly while control bit 1 is set and the block is frozen. `freeze_out` stays high during that time.
- R6: An accepted control write is stored and read back in bits 2:0. Writing 0 drops all requests and does not change the frozen or unfrozen state.
- R7: A control write with both bit 0 and bit 2 set is refused. It sets bit 0 of the refusal log and leaves the state and the control word unchanged.
- R8: A freeze request (bit 0 without bit 2) made while unfreeze-done is clear is refused and sets bit 1 of the refusal log.
- R9: An unfreeze request (bit 2 without bit 0) made while freeze-done is clear is refused and sets bit 2 of the refusal log.
- R10: Refusal-log bits stay set until a write to offset 8 with data bit 0 set clears the whole log to 0. A write to offset 8 with bit 0 clear has no effect.
- R11: Reads of unaligned byte addresses, and of word addresses beyond offset 12, return 0.
- R12: Freeze-done and unfreeze-done are never set at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears the next cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| quiesce_in | input | 1 | Region reports it has no traffic in flight |
| freeze_out | output | 1 | Isolation enable to the traffic gates |
| region_rst | output | 1 | Reset to the reconfigurable region |

## Verification
The bench builds the block with ADDR_W = 6 instead of 4. This adds word addresses past the version register, so a sweep over all 64 byte addresses covers aligned, unaligned and unmapped reads. All eight control values are written in each of the three steady states: unfrozen, waiting for quiet, and frozen. For each one the bench checks the refusal log, status, control readback and both region outputs against a model of the legality rules. Directed sequences check the one-cycle thaw window and that the frozen state waits for the quiet input.

// File: rtl/rgn_iso_pkg.sv
`timescale 1ns/1ps
package rgn_iso_pkg;
    // word index of each register (byte offset / 4); software depends on this order
    localparam int NUM_REGS = 4;
    localparam int REG_STAT = 0;
    localparam int REG_CTRL = 1;
    localparam int REG_ILL  = 2;
    localparam int REG_VER  = 3;

    // control bits
    localparam int CTL_W    = 3;
    localparam int CTL_FRZ  = 0;
    localparam int CTL_RST  = 1;
    localparam int CTL_THAW = 2;

    // status bits
    localparam int ST_FDONE = 0;
    localparam int ST_TDONE = 1;

    // refusal log bits
    localparam int ILL_W    = 3;
    localparam int ILL_BOTH = 0;
    localparam int ILL_FRZ  = 1;
    localparam int ILL_THAW = 2;

    typedef enum logic [1:0] {
        PH_OPEN    = 2'd0,
        PH_CLOSING = 2'd1,
        PH_SHUT    = 2'd2,
        PH_OPENING = 2'd3
    } phase_e;
endpackage

// File: rtl/rgn_iso_regdec.sv
`timescale 1ns/1ps
module rgn_iso_regdec
    import rgn_iso_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] word;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[ADDR_W-1:2];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = aligned && (word == IDX_W'(i));
    end
endmodule

// File: rtl/rgn_iso_seq.sv
`timescale 1ns/1ps
module rgn_iso_seq
    import rgn_iso_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_val,
    input  logic             quiesce_in,
    output logic             freeze_o,
    output logic             fdone_o,
    output logic             tdone_o,
    output logic             accept_o,
    output logic [ILL_W-1:0] ill_ev_o
);
    typedef struct packed {
        phase_e ph;
        logic   frz;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic want_frz, want_thaw, both, bad_frz, bad_thaw;

    always_comb begin
        want_frz  = ctl_val[CTL_FRZ];
        want_thaw = ctl_val[CTL_THAW];
        both      = ctl_wr && want_frz && want_thaw;
        bad_frz   = ctl_wr && want_frz && !want_thaw && (r_q.ph != PH_OPEN);
        bad_thaw  = ctl_wr && want_thaw && !want_frz && (r_q.ph != PH_SHUT);
        accept_o  = ctl_wr && !(both || bad_frz || bad_thaw);

        ill_ev_o           = '0;
        ill_ev_o[ILL_BOTH] = both;
        ill_ev_o[ILL_FRZ]  = bad_frz;
        ill_ev_o[ILL_THAW] = bad_thaw;

        r_d = r_q;
        unique case (r_q.ph)
            PH_OPEN: begin
                if (accept_o && want_frz) r_d.ph = PH_CLOSING;
            end
            PH_CLOSING: begin
                if (quiesce_in) r_d.ph = PH_SHUT;
            end
            PH_SHUT: begin
                if (accept_o && want_thaw) r_d.ph = PH_OPENING;
            end
            PH_OPENING: begin
                r_d.ph = PH_OPEN;
            end
            default: r_d.ph = PH_OPEN;
        endcase
        r_d.frz = (r_d.ph == PH_CLOSING) || (r_d.ph == PH_SHUT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_OPEN, frz: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign freeze_o = r_q.frz;
    assign fdone_o  = (r_q.ph == PH_SHUT);
    assign tdone_o  = (r_q.ph == PH_OPEN);
endmodule

// File: rtl/rgn_iso_errlog.sv
`timescale 1ns/1ps
module rgn_iso_errlog
    import rgn_iso_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ILL_W-1:0] ev,
    input  logic             clr,
    output logic [ILL_W-1:0] log_o
);
    typedef struct packed {
        logic [ILL_W-1:0] flags;
    } log_regs_t;

    log_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr) r_d.flags = '0;
        else     r_d.flags = r_q.flags | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign log_o = r_q.flags;
endmodule

// File: rtl/rgn_iso_ctrl.sv
`timescale 1ns/1ps
module rgn_iso_ctrl
    import rgn_iso_pkg::*;
#(
    parameter int          ADDR_W  = 4,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] VERSION = 32'hAD00_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              quiesce_in,
    output logic              freeze_out,
    output logic              region_rst
);
    typedef struct packed {
        logic [CTL_W-1:0]  ctrl;
        logic [DATA_W-1:0] rdata;
    } top_regs_t;

    top_regs_t r_q, r_d;

    logic [NUM_REGS-1:0] sel;
    logic                fdone, tdone, accept, ill_clr, ctl_wr;
    logic [ILL_W-1:0]    ill_ev, ill_log;
    logic [DATA_W-1:0]   rd_val;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CTL_W];

    rgn_iso_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign ctl_wr  = bus_wr && sel[REG_CTRL];
    assign ill_clr = bus_wr && sel[REG_ILL] && bus_wdata[0];

    rgn_iso_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_val    (bus_wdata[CTL_W-1:0]),
        .quiesce_in (quiesce_in),
        .freeze_o   (freeze_out),
        .fdone_o    (fdone),
        .tdone_o    (tdone),
        .accept_o   (accept),
        .ill_ev_o   (ill_ev)
    );

    rgn_iso_errlog u_log (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ill_ev),
        .clr   (ill_clr),
        .log_o (ill_log)
    );

    always_comb begin
        rd_val = '0;
        if (sel[REG_STAT]) begin
            rd_val[ST_FDONE] = fdone;
            rd_val[ST_TDONE] = tdone;
        end
        if (sel[REG_CTRL]) rd_val[CTL_W-1:0] = r_q.ctrl;
        if (sel[REG_ILL])  rd_val[ILL_W-1:0] = ill_log;
        if (sel[REG_VER])  rd_val[31:0]      = VERSION;

        r_d = r_q;
        if (accept) r_d.ctrl  = bus_wdata[CTL_W-1:0];
        if (bus_rd) r_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata  = r_q.rdata;
    assign region_rst = r_q.ctrl[CTL_RST] && fdone;
endmodule

// File: rtl/rgn_iso_chk.sv
`timescale 1ns/1ps
module rgn_iso_chk
    import rgn_iso_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr,
    input logic             ctrl_sel,
    input logic             ill_sel,
    input logic [CTL_W-1:0] wbits,
    input logic             quiesce_in,
    input logic             freeze_out,
    input logic             region_rst,
    input logic             fdone,
    input logic             tdone,
    input logic [ILL_W-1:0] ill_log
);
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fdone && tdone)); // R12

    AST_FREEZE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ctrl_sel && wbits[CTL_FRZ] && !wbits[CTL_THAW] && tdone) |=> freeze_out); // R3

    AST_FROZEN_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fdone) |-> $past(quiesce_in)); // R3

    AST_THAW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze_out) |=> tdone); // R4

    AST_RST_ONLY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        region_rst |-> (fdone && freeze_out)); // R5

    AST_ZERO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ctrl_sel && (wbits == '0)) |=> $stable(freeze_out)); // R6

    AST_BOTH_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ctrl_sel && wbits[CTL_FRZ] && wbits[CTL_THAW]) |=> ill_log[ILL_BOTH]); // R7

    AST_LOG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && ill_sel && wbits[0]) |=> ((ill_log & $past(ill_log)) == $past(ill_log))); // R10
endmodule

bind rgn_iso_ctrl rgn_iso_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (bus_wr),
    .ctrl_sel   (sel[rgn_iso_pkg::REG_CTRL]),
    .ill_sel    (sel[rgn_iso_pkg::REG_ILL]),
    .wbits      (bus_wdata[rgn_iso_pkg::CTL_W-1:0]),
    .quiesce_in (quiesce_in),
    .freeze_out (freeze_out),
    .region_rst (region_rst),
    .fdone      (fdone),
    .tdone      (tdone),
    .ill_log    (ill_log)
);

// File: tb/rgn_iso_ctrl_test.sv
`timescale 1ns/1ps
module rgn_iso_ctrl_test;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam logic [31:0] VER = 32'hAD00_0003;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          quiesce_in = 1'b0;
    logic          freeze_out, region_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model: 0 unfrozen, 1 waiting for quiet, 2 frozen
    int       m_st = 0;
    logic [2:0] m_ctrl = 3'd0;
    logic [2:0] m_ill = 3'd0;

    always #10 clk = ~clk;

    rgn_iso_ctrl #(.ADDR_W(AW), .DATA_W(DW), .VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .quiesce_in(quiesce_in), .freeze_out(freeze_out), .region_rst(region_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge; each spans one rising edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] stat_of(input int st);
        if (st == 0) return 32'd2;
        if (st == 2) return 32'd1;
        return 32'd0;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        if ((a % 4) != 0 || (a / 4) > 3) return 32'd0;
        case (a / 4)
            0: return stat_of(m_st);
            1: return {29'd0, m_ctrl};
            2: return {29'd0, m_ill};
            default: return VER;
        endcase
    endfunction

    task automatic freeze_finish();
        quiesce_in = 1'b1;
        tick();
        quiesce_in = 1'b0;
        m_st = 2;
    endtask

    task automatic ctl_write(input logic [2:0] v);
        logic both, bf, bu;
        both = v[0] & v[2];
        bf   = v[0] & ~v[2] & (m_st != 0);
        bu   = v[2] & ~v[0] & (m_st != 2);
        m_ill = m_ill | {bu, bf, both};
        wr(6'd4, {29'd0, v});
        if (!(both | bf | bu)) begin
            m_ctrl = v;
            if (v[0] && m_st == 0) m_st = 1;
            else if (v[2] && m_st == 2) begin
                tick();
                m_st = 0;
            end
        end
    endtask

    task automatic goto_state(input int s);
        if (m_st == 1) freeze_finish();
        if (m_st == 2) ctl_write(3'd4);
        if (s >= 1) ctl_write(3'd1);
        if (s == 2) freeze_finish();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 freeze_out", {31'd0, freeze_out}, 32'd0);
        check("R1 region_rst", {31'd0, region_rst}, 32'd0);
        rd(6'd0, d); check("R1 status", d, 32'd2);
        rd(6'd4, d); check("R1 control", d, 32'd0);
        rd(6'd8, d); check("R1 log", d, 32'd0);

        // R2 version and ignored writes
        rd(6'd12, d); check("R2 version", d, VER);
        wr(6'd0, 32'hFFFF_FFFF);
        wr(6'd12, 32'h0);
        rd(6'd0, d); check("R2 status after write", d, 32'd2);
        rd(6'd12, d); check("R2 version after write", d, VER);
        check("R2 freeze_out", {31'd0, freeze_out}, 32'd0);

        // R11 sweep of every byte address
        for (int a = 0; a < 64; a++) begin
            rd(a[AW-1:0], d);
            check("R11 sweep read", d, exp_read(a));
        end

        // R9 unfreeze while unfrozen; R10 clear rules
        wr(6'd4, 32'd4);
        rd(6'd8, d); check("R9 log", d, 32'd4);
        rd(6'd0, d); check("R9 status", d, 32'd2);
        rd(6'd4, d); check("R9 control unchanged", d, 32'd0);
        wr(6'd8, 32'd0);
        rd(6'd8, d); check("R10 write 0 keeps", d, 32'd4);
        wr(6'd8, 32'd1);
        rd(6'd8, d); check("R10 write 1 clears", d, 32'd0);

        // R7 both requests
        wr(6'd4, 32'd5);
        rd(6'd8, d); check("R7 log", d, 32'd1);
        check("R7 freeze_out", {31'd0, freeze_out}, 32'd0);
        rd(6'd4, d); check("R7 control unchanged", d, 32'd0);
        wr(6'd8, 32'd1);

        // R3 freeze waits for quiet
        wr(6'd4, 32'd1);
        check("R3 freeze_out next cycle", {31'd0, freeze_out}, 32'd1);
        rd(6'd0, d); check("R3 status while waiting", d, 32'd0);
        repeat (5) tick();
        rd(6'd0, d); check("R3 status still waiting", d, 32'd0);
        // R8 freeze while waiting
        wr(6'd4, 32'd1);
        rd(6'd8, d); check("R8 log while waiting", d, 32'd2);
        wr(6'd8, 32'd1);
        quiesce_in = 1'b1; tick(); quiesce_in = 1'b0;
        rd(6'd0, d); check("R3 status frozen", d, 32'd1);
        check("R3 freeze_out held", {31'd0, freeze_out}, 32'd1);
        // R8 freeze while frozen
        wr(6'd4, 32'd1);
        rd(6'd8, d); check("R8 log while frozen", d, 32'd2);
        wr(6'd8, 32'd1);

        // R5 reset while frozen, R6 zero write
        wr(6'd4, 32'd2);
        check("R5 region_rst", {31'd0, region_rst}, 32'd1);
        check("R5 freeze_out", {31'd0, freeze_out}, 32'd1);
        rd(6'd4, d); check("R6 control readback", d, 32'd2);
        wr(6'd4, 32'd0);
        check("R5 region_rst released", {31'd0, region_rst}, 32'd0);
        check("R6 freeze_out held", {31'd0, freeze_out}, 32'd1);
        rd(6'd0, d); check("R6 status held", d, 32'd1);
        rd(6'd4, d); check("R6 control cleared", d, 32'd0);

        // R4 unfreeze with one-cycle window
        wr(6'd4, 32'd4);
        check("R4 freeze_out released", {31'd0, freeze_out}, 32'd0);
        rd(6'd0, d); check("R4 status in window", d, 32'd0);
        rd(6'd0, d); check("R4 status unfrozen", d, 32'd2);
        rd(6'd8, d); check("R4 log clean", d, 32'd0);

        // exhaustive: every control value in each steady state
        m_st = 0; m_ctrl = 3'd4; m_ill = 3'd0;
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 8; v++) begin
                string tg;
                goto_state(s);
                wr(6'd8, 32'd1); m_ill = 3'd0;
                ctl_write(v[2:0]);
                tg = (v == 5 || v == 7) ? "R7" :
                     ((v[0] && !v[2]) ? "R8" : ((v[2] && !v[0]) ? "R9" : "R6"));
                rd(6'd8, d); check({tg, " sweep log"}, d, {29'd0, m_ill});
                rd(6'd0, d); check({tg, " sweep status"}, d, stat_of(m_st));
                rd(6'd4, d); check("R6 sweep control", d, {29'd0, m_ctrl});
                check("R3 sweep freeze_out", {31'd0, freeze_out},
                      {31'd0, (m_st != 0)});
                check("R5 sweep region_rst", {31'd0, region_rst},
                      {31'd0, (m_ctrl[1] && m_st == 2)});
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule